// File: doc/BRIEF.md
# Cumulative SCL-Low Timeout Monitor

This block sits beside the client side of a two-wire serial bus and guards it against a bus that never lets go of its clock. It measures how long SCL stays low over one whole transaction. The measurement starts at the opening START and ends at the STOP that follows. The low periods are added together: the total is not restarted when SCL goes high again, and a repeated START does not restart it either. When the total goes past a limit and the timeout is enabled, the block sends two requests to the client protocol engine. One tells the engine to drop any clock stretch it holds. The other resets its state machine.

A timeout clears no interrupt state. The block keeps its own record of whether the address was recognised during the current transaction. The engine forgets that when it is reset, so the block uses this record to raise the stop-received request when the closing STOP arrives. The limit is a count of system clock cycles, set by `TIMEOUT_CYCLES`, which stands for the 25 ms window. The SCL input must already be synchronised, and START and STOP must arrive as one-cycle detect pulses.

Top module: `scl_low_tmo_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `clk_release`, `fsm_reset` and `stop_flag_set` are all 0, and no transaction window is open.
- R2: A transaction window opens on a START and closes on a STOP. Each clock cycle inside the window in which `scl_in` is 0 adds one to the low total. Cycles with `scl_in` at 1 leave the total unchanged. Cycles outside any window are never counted.
- R3: With L = `TIMEOUT_CYCLES`, the timeout fires on the (L+1)-th low cycle counted in the window. `clk_release` and `fsm_reset` are high in the clock cycle that follows that low cycle.
- R4: When `tmo_en` is 0 in the cycle that would fire, no timeout action occurs, however long SCL stays low.
- R5: `clk_release` and `fsm_reset` are always equal, and each pulse lasts exactly one cycle.
- R6: At most one timeout fires per window. A repeated START neither clears the low total nor re-arms the timeout.
- R7: A STOP that closes the window clears the low total, so the next transaction counts from zero.
- R8: The low total saturates at L and cannot wrap. If `tmo_en` is raised after the total has reached L, the timeout fires on the next low cycle.
- R9: `stop_flag_set` pulses for one cycle, in the cycle after a STOP that closes a window, when `addr_match` was high in any cycle of that window. This also holds after a timeout has reset the engine.
- R10: `stop_flag_set` stays 0 in three cases: a STOP that ends a window without an address match, a STOP seen outside any window, and a timeout.
- R11: When START and STOP are flagged in the same cycle, the START wins. The window stays open and is treated as a repeated START, so the low total is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised SCL level |
| start_det | input | 1 | One-cycle START (or repeated START) detect pulse |
| stop_det | input | 1 | One-cycle STOP detect pulse |
| tmo_en | input | 1 | Enables the timeout action |
| addr_match | input | 1 | High when the client engine has recognised its address |
| clk_release | output | 1 | One-cycle request to drop any SCL stretch |
| fsm_reset | output | 1 | One-cycle reset request for the client protocol state machine |
| stop_flag_set | output | 1 | One-cycle request to set the stop-received interrupt flag |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 20, so a full timeout takes a few dozen cycles instead of millions. With that value each test can place the firing cycle exactly, split the low time across several SCL-high gaps and repeated STARTs, and run lows long enough to exceed the 5-bit counter range. That last case shows whether the counter saturates or wraps. With the short limit, one run also covers the combined cases: a timeout followed by a STOP with the address recognised, and a START and STOP flagged in the same cycle.

// File: rtl/slt_pkg.sv
package slt_pkg;

  // Window events decoded from the START/STOP detect pulses
  typedef struct packed {
    logic open_new;  // START with no window open
    logic close;     // STOP ending an open window (START not present)
  } win_evt_t;

endpackage

// File: rtl/slt_window.sv
module slt_window
  import slt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_det,
  input  logic     stop_det,
  input  logic     addr_match,
  output win_evt_t evt,
  output logic     in_txn,
  output logic     stop_flag_set
);

  logic in_txn_d;
  logic addr_seen_q, addr_seen_d;
  logic sflag_q, sflag_d;
  logic win_en, addr_en;

  // event decode: START wins over STOP in the same cycle
  always_comb begin
    evt.open_new = start_det && !in_txn;
    evt.close    = stop_det && !start_det && in_txn;
  end

  // next-state logic
  always_comb begin
    win_en   = start_det || evt.close;
    in_txn_d = start_det;

    addr_en     = evt.open_new || evt.close || (in_txn && addr_match);
    addr_seen_d = in_txn && addr_match && !evt.close;

    sflag_d = evt.close && (addr_seen_q || addr_match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_txn      <= 1'b0;
      addr_seen_q <= 1'b0;
      sflag_q     <= 1'b0;
    end else begin
      if (win_en)  in_txn      <= in_txn_d;
      if (addr_en) addr_seen_q <= addr_seen_d;
      sflag_q <= sflag_d;
    end
  end

  assign stop_flag_set = sflag_q;

  p_start_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> in_txn);

  p_stop_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag_set |-> ($past(stop_det) && !$past(start_det)));

  p_stop_flag_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag_set |=> !stop_flag_set);

endmodule

// File: rtl/slt_accum.sv
module slt_accum
  import slt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2_500_000,
  parameter int unsigned CNT_W          = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_evt_t         evt,
  input  logic             in_txn,
  input  logic             scl_in,
  output logic [CNT_W-1:0] acc,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] acc_q, acc_d;
  logic             acc_clr, acc_inc, acc_en;

  always_comb begin
    acc_clr = evt.open_new || evt.close;
    acc_inc = in_txn && !scl_in && (acc_q != LIMIT);
    acc_en  = acc_clr || acc_inc;
    if (acc_clr) acc_d = '0;
    else         acc_d = acc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc      = acc_q;
  assign at_limit = (acc_q == LIMIT);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= LIMIT);

  p_hold_when_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && !evt.open_new && !evt.close) |=> $stable(acc_q));

  p_idle_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_txn && !evt.open_new) |=> $stable(acc_q));

  p_clear_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.close |=> (acc_q == '0));

endmodule

// File: rtl/slt_action.sv
module slt_action
  import slt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tmo_en,
  input  logic     in_txn,
  input  logic     scl_in,
  input  logic     at_limit,
  input  win_evt_t evt,
  output logic     clk_release,
  output logic     fsm_reset
);

  logic fired_q, fired_d, fired_en;
  logic hit;
  logic rel_q, rst_q;

  always_comb begin
    hit      = tmo_en && in_txn && !scl_in && at_limit && !fired_q && !evt.close;
    fired_en = hit || evt.close || evt.open_new;
    fired_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      rel_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (fired_en) fired_q <= fired_d;
      rel_q <= hit;
      rst_q <= hit;
    end
  end

  assign clk_release = rel_q;
  assign fsm_reset   = rst_q;

  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_release == fsm_reset);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_release |=> !clk_release);

  p_no_fire_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |=> !clk_release);

  p_once_per_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !evt.close && !evt.open_new) |=> !clk_release);

  p_fire_needs_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !at_limit |=> !clk_release);

endmodule

// File: rtl/scl_low_tmo_mon.sv
module scl_low_tmo_mon #(
  parameter int unsigned TIMEOUT_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic start_det,
  input  logic stop_det,
  input  logic tmo_en,
  input  logic addr_match,
  output logic clk_release,
  output logic fsm_reset,
  output logic stop_flag_set
);
  import slt_pkg::*;

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  win_evt_t         evt;
  logic             in_txn;
  logic [CNT_W-1:0] acc;
  logic             at_limit;

  slt_window u_window (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .addr_match    (addr_match),
    .evt           (evt),
    .in_txn        (in_txn),
    .stop_flag_set (stop_flag_set)
  );

  slt_accum #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .CNT_W          (CNT_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .in_txn   (in_txn),
    .scl_in   (scl_in),
    .acc      (acc),
    .at_limit (at_limit)
  );

  slt_action u_action (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmo_en      (tmo_en),
    .in_txn      (in_txn),
    .scl_in      (scl_in),
    .at_limit    (at_limit),
    .evt         (evt),
    .clk_release (clk_release),
    .fsm_reset   (fsm_reset)
  );

  p_timeout_no_stop_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_release |-> !stop_flag_set);

  p_release_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_release |-> (acc != '0));

endmodule

// File: tb/scl_low_tmo_mon_bench.sv
module scl_low_tmo_mon_bench;

  localparam int unsigned L = 20;

  logic clk = 1'b0;
  logic rst_n, scl, start_det, stop_det, en, addr;
  logic rel, frst, sflag;

  int checks = 0;
  int fails  = 0;
  bit pair_bad  = 1'b0;
  bit sflag_bad = 1'b0;

  always #2 clk = ~clk;

  scl_low_tmo_mon #(.TIMEOUT_CYCLES(L)) u_scl_low_tmo_mon (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .tmo_en        (en),
    .addr_match    (addr),
    .clk_release   (rel),
    .fsm_reset     (frst),
    .stop_flag_set (sflag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive SCL at lvl for n cycles; report index of the release pulse (0 none, -1 more than one)
  task automatic drive_scl(input logic lvl, input int n, output int seen_at);
    seen_at = 0;
    for (int i = 1; i <= n; i++) begin
      scl = lvl;
      @(negedge clk);
      if (rel !== frst) pair_bad = 1'b1;
      if (sflag !== 1'b0) sflag_bad = 1'b1;
      if (rel === 1'b1) seen_at = (seen_at == 0) ? i : -1;
    end
  endtask

  task automatic send_start();
    scl = 1'b1; start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic send_stop(output logic flag);
    scl = 1'b1; stop_det = 1'b1;
    @(negedge clk);
    flag = sflag;
    stop_det = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; scl = 1'b1; start_det = 1'b0; stop_det = 1'b0; en = 1'b1; addr = 1'b0;
    repeat (3) @(negedge clk);
    chk(rel === 1'b0 && frst === 1'b0 && sflag === 1'b0, "R1 outputs in reset", rel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rel === 1'b0 && frst === 1'b0 && sflag === 1'b0, "R1 outputs after reset", rel, 0);
  endtask

  task automatic t_outside_window();
    int s;
    logic f;
    drive_scl(1'b0, 30, s);
    chk(s == 0, "R2 no fire outside window", s, 0);
    send_start();
    drive_scl(1'b0, L, s);
    chk(s == 0, "R2 idle lows not counted", s, 0);
    drive_scl(1'b0, 1, s);
    chk(s == 1, "R3 fires on low L+1", s, 1);
    send_stop(f);
  endtask

  task automatic t_cumulative();
    int s;
    logic f;
    send_start();
    drive_scl(1'b0, 8, s);
    chk(s == 0, "R2 first interval", s, 0);
    drive_scl(1'b1, 5, s);
    drive_scl(1'b0, 8, s);
    chk(s == 0, "R2 second interval", s, 0);
    drive_scl(1'b1, 3, s);
    drive_scl(1'b0, 5, s);
    chk(s == 5, "R3 cumulative fire cycle", s, 5);
    drive_scl(1'b0, 10, s);
    chk(s == 0, "R6 no second fire", s, 0);
    send_stop(f);
    chk(f == 1'b0, "R10 no addr no stop flag", f, 0);
  endtask

  task automatic t_disabled();
    int s;
    logic f;
    en = 1'b0;
    send_start();
    drive_scl(1'b0, 40, s);
    chk(s == 0, "R4 disabled never fires", s, 0);
    send_stop(f);
    en = 1'b1;
  endtask

  task automatic t_late_enable();
    int s;
    logic f;
    en = 1'b0;
    send_start();
    drive_scl(1'b0, 50, s);
    chk(s == 0, "R4 disabled long low", s, 0);
    en = 1'b1;
    drive_scl(1'b0, 1, s);
    chk(s == 1, "R8 saturated total fires next low", s, 1);
    send_stop(f);
  endtask

  task automatic t_stop_clears();
    int s;
    logic f;
    send_start();
    drive_scl(1'b0, 15, s);
    send_stop(f);
    send_start();
    drive_scl(1'b0, 15, s);
    chk(s == 0, "R7 total cleared by stop", s, 0);
    drive_scl(1'b0, 6, s);
    chk(s == 6, "R7 new window counts from zero", s, 6);
    send_stop(f);
  endtask

  task automatic t_repeated_start();
    int s;
    logic f;
    send_start();
    drive_scl(1'b0, 15, s);
    send_start();
    drive_scl(1'b0, 6, s);
    chk(s == 6, "R6 repeated start keeps total", s, 6);
    send_start();
    drive_scl(1'b0, 10, s);
    chk(s == 0, "R6 repeated start does not re-arm", s, 0);
    send_stop(f);
  endtask

  task automatic t_stop_flag();
    int s;
    logic f;
    send_start();
    addr = 1'b1;
    drive_scl(1'b1, 1, s);
    addr = 1'b0;
    drive_scl(1'b0, L + 1, s);
    chk(s == L + 1, "R3 fire after address", s, L + 1);
    send_stop(f);
    chk(f == 1'b1, "R9 stop flag after timeout", f, 1);
    @(negedge clk);
    chk(sflag === 1'b0, "R9 stop flag single cycle", sflag, 0);
    send_start();
    drive_scl(1'b0, 3, s);
    send_stop(f);
    chk(f == 1'b0, "R10 no address no flag", f, 0);
    send_stop(f);
    chk(f == 1'b0, "R10 stop outside window", f, 0);
  endtask

  task automatic t_start_stop_same();
    int s;
    logic f;
    send_start();
    drive_scl(1'b0, 10, s);
    scl = 1'b1; start_det = 1'b1; stop_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0; stop_det = 1'b0;
    drive_scl(1'b0, 11, s);
    chk(s == 11, "R11 start wins over stop", s, 11);
    send_stop(f);
  endtask

  initial begin
    t_reset();
    t_outside_window();
    t_cumulative();
    t_disabled();
    t_late_enable();
    t_stop_clears();
    t_repeated_start();
    t_stop_flag();
    t_start_stop_same();
    chk(!pair_bad, "R5 release and reset equal", pair_bad, 0);
    chk(!sflag_bad, "R10 no stop flag during SCL activity", sflag_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule